// File: doc/BRIEF.md
# Multicycle Sixteen-Register Controller-Datapath Processor

This block is a small processor split into a controller state machine and a datapath. The datapath holds a sixteen-entry register file, one adder/subtractor, a program counter and an instruction register, and it reaches memory through a single shared port. Every instruction is one 16-bit word. The top four bits choose the operation. Bits 11:8 name the register Rn. The low byte is a memory address, an immediate, a signed jump offset, or a second register Rm in bits 7:4, depending on the operation.

The memory sits outside the block. It answers a read one clock after the read enable and address are presented, and it commits a write on the clock edge where the write enable is high. The three-input address multiplexer picks the program counter, the direct byte of the instruction, or register read port 1. Every instruction takes three cycles of fetch, wait and decode, followed by one execute cycle. Loads take one more execute cycle while they wait for the read data.

Top module: `tmc_core`

## Requirements
- R1: While `rst` is high, neither memory enable is asserted. After `rst` falls, the first memory access is an instruction read at address 0.
- R2: An instruction read uses the program counter as the address, and the program counter then advances by one, modulo 2^ADDR_W. A one-cycle instruction issues its next fetch 4 cycles after its own fetch. Opcode 0000 issues its data read 3 cycles after its fetch and the next fetch 5 cycles after it.
- R3: Opcode 0000 copies the full 16-bit word at memory address ir[7:0] into Rn (Rn = ir[11:8]).
- R4: Opcode 0001 writes Rn to memory address ir[7:0].
- R5: Opcode 0010 writes Rm (Rm = ir[7:4]) to the memory address given by the low 8 bits of Rn. The upper bits of Rn are ignored.
- R6: Opcode 0011 loads Rn with ir[7:0], zero-extended to 16 bits.
- R7: Opcode 0100 sets Rn to Rn + Rm, modulo 2^16.
- R8: Opcode 0101 sets Rn to Rn - Rm, modulo 2^16.
- R9: Opcode 0110 tests Rn. If Rn is zero, the program counter becomes the address that follows the jump plus ir[7:0] sign-extended, modulo 256, in either direction and across the top of memory. If Rn is not zero, execution falls through.
- R10: Opcodes 0111 to 1111 change no register and no memory. They go back to fetch right after decode, so the next fetch comes 3 cycles after their own.
- R11: Read and write enables are never high together. A write happens only while a store instruction executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd_en | output | 1 | Read request; data is returned the next cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after the request |

## Verification
The bench uses the default build: 16-bit data and an 8-bit address. The whole 256-word memory therefore fits in the bench, and the program counter can be pushed over the top of memory and back. With that build the bench can sweep every immediate value, every zero and non-zero jump operand, and all nine unused opcodes. It also covers a 16-by-16 grid of operand pairs for add and subtract, including 0, 0x8000 and 0xFFFF. Each result is compared against sums, differences and triangular numbers that the bench computes itself.

// File: rtl/tmc_pkg.sv
`timescale 1ns/1ps
package tmc_pkg;

    localparam int INSTR_W  = 16;
    localparam int RSEL_W   = 4;
    localparam int RF_DEPTH = 1 << RSEL_W;

    localparam logic [3:0] OPC_LDD = 4'b0000;
    localparam logic [3:0] OPC_STD = 4'b0001;
    localparam logic [3:0] OPC_STI = 4'b0010;
    localparam logic [3:0] OPC_LDI = 4'b0011;
    localparam logic [3:0] OPC_ADD = 4'b0100;
    localparam logic [3:0] OPC_SUB = 4'b0101;
    localparam logic [3:0] OPC_JZ  = 4'b0110;

    typedef enum logic [1:0] {
        AMUX_REG = 2'b00,
        AMUX_DIR = 2'b01,
        AMUX_PC  = 2'b10
    } amux_e;

    typedef enum logic [1:0] {
        WMUX_ALU = 2'b00,
        WMUX_MEM = 2'b01,
        WMUX_IMM = 2'b10
    } wmux_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01
    } alu_op_e;

    typedef enum logic [3:0] {
        ST_RESET, ST_FETCH, ST_FWAIT, ST_DECODE,
        ST_LDD, ST_LDW, ST_STD, ST_STI,
        ST_LDI, ST_ADD, ST_SUB, ST_JZ
    } state_e;

    typedef struct packed {
        logic              pc_clr;
        logic              pc_inc;
        logic              pc_ld;
        logic              ir_ld;
        amux_e             asel;
        logic              mre;
        logic              mwe;
        logic [RSEL_W-1:0] wa;
        logic              we;
        wmux_e             wsel;
        logic [RSEL_W-1:0] ra1;
        logic              re1;
        logic [RSEL_W-1:0] ra2;
        logic              re2;
        alu_op_e           aop;
    } ctrl_t;

    function automatic logic [3:0] f_opc(input logic [INSTR_W-1:4] f);
        return f[15:12];
    endfunction

    function automatic logic [RSEL_W-1:0] f_rn(input logic [INSTR_W-1:4] f);
        return f[11:8];
    endfunction

    function automatic logic [RSEL_W-1:0] f_rm(input logic [INSTR_W-1:4] f);
        return f[7:4];
    endfunction

endpackage

// File: rtl/tmc_alu.sv
`timescale 1ns/1ps
module tmc_alu
    import tmc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] y,
    output logic              zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = a;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/tmc_rf.sv
`timescale 1ns/1ps
module tmc_rf
    import tmc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [RSEL_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    input  logic              re1,
    input  logic [RSEL_W-1:0] ra1,
    output logic [DATA_W-1:0] rd1,
    input  logic              re2,
    input  logic [RSEL_W-1:0] ra2,
    output logic [DATA_W-1:0] rd2
);

    localparam int NPORT = 2;

    logic [DATA_W-1:0] regs [RF_DEPTH];
    logic              rev  [NPORT];
    logic [RSEL_W-1:0] rav  [NPORT];
    logic [DATA_W-1:0] rdv  [NPORT];

    always_ff @(posedge clk) begin
        if (we) regs[wa] <= wd;
    end

    assign rev[0] = re1;
    assign rev[1] = re2;
    assign rav[0] = ra1;
    assign rav[1] = ra2;

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rdv[p] = rev[p] ? regs[rav[p]] : '0;
    end

    assign rd1 = rdv[0];
    assign rd2 = rdv[1];

endmodule

// File: rtl/tmc_ctrl.sv
`timescale 1ns/1ps
module tmc_ctrl
    import tmc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:4] ifield,
    input  logic               alu_zero,
    output ctrl_t              ctl,
    output state_e             state
);

    state_e nxt;
    logic [3:0]        opc;
    logic [RSEL_W-1:0] rn, rm;

    assign opc = f_opc(ifield);
    assign rn  = f_rn(ifield);
    assign rm  = f_rm(ifield);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RESET;
        else     state <= nxt;
    end

    always_comb begin
        ctl = '0;
        nxt = state;
        unique case (state)
            ST_RESET: begin
                ctl.pc_clr = 1'b1;
                nxt = ST_FETCH;
            end
            ST_FETCH: begin
                ctl.asel = AMUX_PC;
                ctl.mre  = 1'b1;
                nxt = ST_FWAIT;
            end
            ST_FWAIT: begin
                ctl.ir_ld  = 1'b1;
                ctl.pc_inc = 1'b1;
                nxt = ST_DECODE;
            end
            ST_DECODE: begin
                unique case (opc)
                    OPC_LDD: nxt = ST_LDD;
                    OPC_STD: nxt = ST_STD;
                    OPC_STI: nxt = ST_STI;
                    OPC_LDI: nxt = ST_LDI;
                    OPC_ADD: nxt = ST_ADD;
                    OPC_SUB: nxt = ST_SUB;
                    OPC_JZ:  nxt = ST_JZ;
                    default: nxt = ST_FETCH;
                endcase
            end
            ST_LDD: begin
                ctl.asel = AMUX_DIR;
                ctl.mre  = 1'b1;
                nxt = ST_LDW;
            end
            ST_LDW: begin
                ctl.wa   = rn;
                ctl.we   = 1'b1;
                ctl.wsel = WMUX_MEM;
                nxt = ST_FETCH;
            end
            ST_STD: begin
                ctl.asel = AMUX_DIR;
                ctl.ra2  = rn;
                ctl.re2  = 1'b1;
                ctl.mwe  = 1'b1;
                nxt = ST_FETCH;
            end
            ST_STI: begin
                ctl.asel = AMUX_REG;
                ctl.ra1  = rn;
                ctl.re1  = 1'b1;
                ctl.ra2  = rm;
                ctl.re2  = 1'b1;
                ctl.mwe  = 1'b1;
                nxt = ST_FETCH;
            end
            ST_LDI: begin
                ctl.wa   = rn;
                ctl.we   = 1'b1;
                ctl.wsel = WMUX_IMM;
                nxt = ST_FETCH;
            end
            ST_ADD, ST_SUB: begin
                ctl.wa   = rn;
                ctl.we   = 1'b1;
                ctl.wsel = WMUX_ALU;
                ctl.ra1  = rn;
                ctl.re1  = 1'b1;
                ctl.ra2  = rm;
                ctl.re2  = 1'b1;
                ctl.aop  = (state == ST_SUB) ? ALU_SUB : ALU_ADD;
                nxt = ST_FETCH;
            end
            ST_JZ: begin
                ctl.ra1   = rn;
                ctl.re1   = 1'b1;
                ctl.aop   = ALU_ADD;
                ctl.pc_ld = alu_zero;
                nxt = ST_FETCH;
            end
            default: nxt = ST_RESET;
        endcase
    end

endmodule

// File: rtl/tmc_core.sv
`timescale 1ns/1ps
module tmc_core
    import tmc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

    ctrl_t              ctl;
    state_e             state;
    logic [ADDR_W-1:0]  pc_q;
    logic [INSTR_W-1:0] ir_q;
    logic [DATA_W-1:0]  rd1, rd2, alu_y, wd;
    logic               alu_z;
    logic [ADDR_W-1:0]  rel_ext;

    tmc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ifield   (ir_q[INSTR_W-1:4]),
        .alu_zero (alu_z),
        .ctl      (ctl),
        .state    (state)
    );

    tmc_rf #(.DATA_W(DATA_W)) u_rf (
        .clk (clk),
        .we  (ctl.we),
        .wa  (ctl.wa),
        .wd  (wd),
        .re1 (ctl.re1),
        .ra1 (ctl.ra1),
        .rd1 (rd1),
        .re2 (ctl.re2),
        .ra2 (ctl.ra2),
        .rd2 (rd2)
    );

    tmc_alu #(.DATA_W(DATA_W)) u_alu (
        .a    (rd1),
        .b    (rd2),
        .op   (ctl.aop),
        .y    (alu_y),
        .zero (alu_z)
    );

    assign rel_ext = ADDR_W'($signed(ir_q[7:0]));

    always_ff @(posedge clk) begin
        if (rst)             pc_q <= '0;
        else if (ctl.pc_clr) pc_q <= '0;
        else if (ctl.pc_ld)  pc_q <= pc_q + rel_ext;
        else if (ctl.pc_inc) pc_q <= pc_q + PC_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst)            ir_q <= '0;
        else if (ctl.ir_ld) ir_q <= mem_rdata[INSTR_W-1:0];
    end

    always_comb begin
        unique case (ctl.asel)
            AMUX_REG: mem_addr = ADDR_W'(rd1);
            AMUX_DIR: mem_addr = ADDR_W'(ir_q[7:0]);
            default:  mem_addr = pc_q;
        endcase
    end

    always_comb begin
        unique case (ctl.wsel)
            WMUX_MEM: wd = mem_rdata;
            WMUX_IMM: wd = DATA_W'(ir_q[7:0]);
            default:  wd = alu_y;
        endcase
    end

    assign mem_rd_en = ctl.mre;
    assign mem_wr_en = ctl.mwe;
    assign mem_wdata = rd2;

endmodule

// File: rtl/tmc_chk.sv
`timescale 1ns/1ps
module tmc_chk
    import tmc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input state_e            state,
    input logic [ADDR_W-1:0] pc,
    input logic [3:0]        opc,
    input logic              alu_zero,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd_en,
    input logic              mem_wr_en
);

    // R1
    reset_pc_chk: assert property (@(posedge clk) rst |=> (pc == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RESET) |-> (!mem_rd_en && !mem_wr_en));

    // R2
    fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |-> (mem_rd_en && mem_addr == pc));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FWAIT) |=> (pc == ADDR_W'($past(pc) + 1)));

    // R9
    jz_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_JZ && !alu_zero) |=> $stable(pc));

    // R10
    idle_op_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && opc > 4'd6) |=> (state == ST_FETCH));

    // R11
    excl_en_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));

    // R11
    wr_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> (state == ST_FETCH));

endmodule

bind tmc_core tmc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .pc        (pc_q),
    .opc       (ir_q[15:12]),
    .alu_zero  (alu_z),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en)
);

// File: tb/sim_tmc_core.sv
`timescale 1ns/1ps
module sim_tmc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    logic [15:0] img [256];
    logic [15:0] mem [256];
    int          cyc = 0;
    int          log_n = 0;
    int          wr_n = 0;
    int          both_n = 0;
    logic [7:0]  log_a [64];
    int          log_c [64];
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    tmc_core u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            log_n <= 0;
            wr_n  <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= img[i];
        end else begin
            if (mem_rd_en && mem_wr_en) both_n <= both_n + 1;
            if (mem_rd_en) begin
                mem_rdata <= mem[mem_addr];
                if (log_n < 64) begin
                    log_a[log_n] <= mem_addr;
                    log_c[log_n] <= cyc;
                    log_n <= log_n + 1;
                end
            end
            if (mem_wr_en) begin
                mem[mem_addr] <= mem_wdata;
                wr_n <= wr_n + 1;
            end
        end
    end

    function automatic logic [15:0] ins(input int op, input int rn, input int lo);
        return {op[3:0], rn[3:0], lo[7:0]};
    endfunction

    function automatic logic [15:0] val(input int i);
        case (i)
            0:       return 16'h0000;
            8:       return 16'h8000;
            15:      return 16'hFFFF;
            default: return 16'((i * 16'h1F3D) ^ 16'h0A50);
        endcase
    endfunction

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 16'hC000 | 16'(i);
    endtask

    task automatic run(input int n);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset quiet, first access is fetch at 0
        clear_img();
        img[0] = ins(3, 15, 0);
        img[1] = ins(6, 15, 8'hFF);
        @(negedge clk) rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 no read in reset", 32'(mem_rd_en), 32'd0);
        chk("R1 no write in reset", 32'(mem_wr_en), 32'd0);
        run(20);
        chk("R1 first fetch address", 32'(log_a[0]), 32'd0);

        // R2 / R3 timing of fetch and load
        clear_img();
        img[0] = ins(3, 15, 0);
        img[1] = ins(0, 1, 8'hF0);
        img[2] = ins(6, 15, 8'hFF);
        run(30);
        chk("R2 fetch order addr1", 32'(log_a[1]), 32'd1);
        chk("R2 one-cycle op fetch gap", 32'(log_c[1] - log_c[0]), 32'd4);
        chk("R3 load data address", 32'(log_a[2]), 32'hF0);
        chk("R2 load data read gap", 32'(log_c[2] - log_c[1]), 32'd3);
        chk("R2 load next fetch addr", 32'(log_a[3]), 32'd2);
        chk("R2 load next fetch gap", 32'(log_c[3] - log_c[1]), 32'd5);

        // R3 R4 R7 R8: operand grid
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                clear_img();
                img[0] = ins(3, 15, 0);
                img[1] = ins(0, 1, 8'hF0);
                img[2] = ins(0, 2, 8'hF1);
                img[3] = ins(4, 1, 8'h20);
                img[4] = ins(1, 1, 8'hE0);
                img[5] = ins(0, 1, 8'hF0);
                img[6] = ins(5, 1, 8'h20);
                img[7] = ins(1, 1, 8'hE1);
                img[8] = ins(6, 15, 8'hFF);
                img[8'hF0] = val(i);
                img[8'hF1] = val(j);
                run(50);
                chk("R7 add via R3 load and R4 store", 32'(mem[8'hE0]), 32'(16'(val(i) + val(j))));
                chk("R8 subtract", 32'(mem[8'hE1]), 32'(16'(val(i) - val(j))));
            end
        end

        // R6: all immediates
        for (int k = 0; k < 256; k++) begin
            clear_img();
            img[0] = ins(3, 15, 0);
            img[1] = ins(3, 1 + k % 14, k);
            img[2] = ins(1, 1 + k % 14, 8'hE2);
            img[3] = ins(6, 15, 8'hFF);
            run(25);
            chk("R6 immediate zero-extend", 32'(mem[8'hE2]), 32'(k));
        end

        // R5: indirect store, upper bits of Rn ignored
        for (int j = 0; j < 16; j++) begin
            clear_img();
            img[0] = ins(3, 15, 0);
            img[1] = ins(0, 4, 8'hF0);
            img[2] = ins(0, 5, 8'hF1);
            img[3] = ins(2, 4, 8'h50);
            img[4] = ins(6, 15, 8'hFF);
            img[8'hF0] = 16'hA5C0 | 16'(j);
            img[8'hF1] = val(j) ^ 16'h3C3C;
            run(40);
            chk("R5 indirect target", 32'(mem[8'hC0 + j]), 32'(val(j) ^ 16'h3C3C));
            chk("R5 neighbour untouched", 32'(mem[8'hC0 + (j + 1) % 16]),
                32'(16'hC000 | 16'(8'hC0 + (j + 1) % 16)));
        end

        // R9: jump taken only on zero
        for (int z = 0; z < 256; z++) begin
            clear_img();
            img[0] = ins(3, 15, 0);
            img[1] = ins(3, 7, 8'h22);
            img[2] = ins(3, 6, z);
            img[3] = ins(6, 6, 8'h01);
            img[4] = ins(3, 7, 8'h11);
            img[5] = ins(1, 7, 8'hE3);
            img[6] = ins(6, 15, 8'hFF);
            run(40);
            chk("R9 zero test", 32'(mem[8'hE3]), (z == 0) ? 32'h22 : 32'h11);
        end

        // R9 backward loop with R7 R8: sum n..1
        for (int n = 0; n <= 20; n++) begin
            clear_img();
            img[0]  = ins(3, 15, 0);
            img[1]  = ins(3, 0, 0);
            img[2]  = ins(3, 1, n);
            img[3]  = ins(3, 2, 1);
            img[4]  = ins(3, 3, 0);
            img[5]  = ins(6, 1, 8'h03);
            img[6]  = ins(4, 0, 8'h10);
            img[7]  = ins(5, 1, 8'h20);
            img[8]  = ins(6, 3, 8'hFC);
            img[9]  = ins(1, 0, 8'hE4);
            img[10] = ins(6, 15, 8'hFF);
            run(420);
            chk("R9 backward loop sum", 32'(mem[8'hE4]), 32'(n * (n + 1) / 2));
        end

        // R9 wrap across top of memory both ways
        clear_img();
        img[0]     = ins(3, 15, 0);
        img[1]     = ins(6, 15, 8'hFD);
        img[2]     = ins(3, 8, 8'h77);
        img[3]     = ins(3, 8, 8'h5A);
        img[4]     = ins(1, 8, 8'hE5);
        img[5]     = ins(6, 15, 8'hFF);
        img[8'hFF] = ins(6, 15, 8'h03);
        run(60);
        chk("R9 wrap fetch at top", 32'(log_a[2]), 32'hFF);
        chk("R9 wrap result", 32'(mem[8'hE5]), 32'h5A);

        // R10 / R11: unused opcodes
        for (int op = 7; op < 16; op++) begin
            clear_img();
            img[0] = ins(3, 15, 0);
            img[1] = ins(3, 9, 8'h33);
            img[2] = ins(op, 9, 8'h5A);
            img[3] = ins(1, 9, 8'hE6);
            img[4] = ins(6, 15, 8'hFF);
            run(40);
            chk("R10 register unchanged", 32'(mem[8'hE6]), 32'h33);
            chk("R10 memory unchanged", 32'(mem[8'h5A]), 32'hC05A);
            chk("R10 fetch gap", 32'(log_c[3] - log_c[2]), 32'd3);
            chk("R11 writes only by store", 32'(wr_n), 32'd1);
        end

        chk("R11 enables exclusive", 32'(both_n), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule